// File: doc/BRIEF.md
# Modulo 2^k-1 Prefix Adder with Excess-One Correction

This block adds two residues modulo 2^k-1 in a single combinational path. One parallel prefix network forms the ordinary k-bit sum of the operands. It also forms the group generate, which is the carry out of the whole word, and the group propagate, which is set when every bit of a XOR b is one.

A correction stage then adds one to the plain sum whenever either of those two group signals is set. This handles the end-around carry. It also turns an all-ones result into zero, so zero has a single encoding. No second carry network and no second sum stage are needed.

The block is used wherever residues of a 2^k-1 channel must be combined, for example inside a residue-to-binary converter. Both operands must already be reduced, which means each lies in 0 .. 2^k-2.

Top module: `modm1_prefix_adder`

## Requirements
- R1: For operands a, b in 0 .. 2^k-2, sum_o equals (a + b) mod (2^k - 1), for every width k >= 2 set by the parameter WIDTH.
- R2: sum_o is never all ones. When a + b equals exactly 2^k-1 (a XOR b all ones), sum_o is 0.
- R3: When a + b >= 2^k, the carry out is folded back into bit 0, so that sum_o = a + b - 2^k + 1.
- R4: When a + b < 2^k - 1, sum_o equals a + b unchanged.
- R5: Adding zero to an operand returns that operand (a + 0 = a, 0 + b = b, 0 + 0 = 0).
- R6: The same structure is correct for a narrow width (k = 3) as for the default width (k = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First residue operand, 0 .. 2^WIDTH-2 |
| b_i | input | WIDTH | Second residue operand, 0 .. 2^WIDTH-2 |
| sum_o | output | WIDTH | Residue sum modulo 2^WIDTH-1 |

## Verification
Assertions inside the modules are evaluated whenever the inputs change:
- sum_o stays below 2^k-1, and zero never appears as all ones.
- The group propagate and group generate are never set together.
- The correction stage either passes the plain sum through or adds exactly one to it, according to its select.

Only the bench's scenarios show that the full result matches the modular sum for every operand pair. The bench covers all 65025 pairs at k = 8 and all pairs at k = 3, and classifies each pair as the wrap-to-zero, carry-fold, no-carry or zero-operand case.

// File: rtl/modm1_pkg.sv
package modm1_pkg;
  // Number of prefix levels needed to cover a word of w bits.
  function automatic int unsigned prefix_levels(input int unsigned w);
    int unsigned n;
    n = 0;
    while ((1 << n) < w) n++;
    return n;
  endfunction
endpackage

// File: rtl/modm1_prefix_net.sv
module modm1_prefix_net #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] plain_sum_o,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);
  localparam int unsigned LEVELS = modm1_pkg::prefix_levels(WIDTH);

  logic [WIDTH-1:0] gen_l  [0:LEVELS];
  logic [WIDTH-1:0] prop_l [0:LEVELS];
  logic [WIDTH-1:0] half_x;
  logic [WIDTH-1:0] carry_in;

  assign half_x    = a_i ^ b_i;
  assign gen_l[0]  = a_i & b_i;
  assign prop_l[0] = half_x;

  // Kogge-Stone style combination of (generate, propagate) pairs.
  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
    localparam int unsigned DIST = 1 << lvl;
    for (genvar bit_i = 0; bit_i < WIDTH; bit_i++) begin : g_bit
      if (bit_i >= DIST) begin : g_merge
        assign gen_l[lvl+1][bit_i]  = gen_l[lvl][bit_i] |
                                      (prop_l[lvl][bit_i] & gen_l[lvl][bit_i-DIST]);
        assign prop_l[lvl+1][bit_i] = prop_l[lvl][bit_i] & prop_l[lvl][bit_i-DIST];
      end else begin : g_pass
        assign gen_l[lvl+1][bit_i]  = gen_l[lvl][bit_i];
        assign prop_l[lvl+1][bit_i] = prop_l[lvl][bit_i];
      end
    end
  end

  assign carry_in    = {gen_l[LEVELS][WIDTH-2:0], 1'b0};
  assign plain_sum_o = half_x ^ carry_in;
  assign grp_gen_o   = gen_l[LEVELS][WIDTH-1];
  assign grp_prop_o  = prop_l[LEVELS][WIDTH-1];

  // A word that propagates everywhere cannot also generate a carry out.
  always_comb begin
    AST_PROP_EXCLUDES_GEN: assert (!(grp_prop_o && grp_gen_o)); // R2
  end
endmodule

// File: rtl/modm1_excess_one.sv
module modm1_excess_one #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int unsigned LEVELS = modm1_pkg::prefix_levels(WIDTH);

  logic [WIDTH-1:0] ones_l [0:LEVELS];

  // ones_l[LEVELS][i] is set when every bit of sum_i below position i is one.
  assign ones_l[0] = {sum_i[WIDTH-2:0], 1'b1};

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
    localparam int unsigned DIST = 1 << lvl;
    for (genvar bit_i = 0; bit_i < WIDTH; bit_i++) begin : g_bit
      if (bit_i >= DIST) begin : g_and
        assign ones_l[lvl+1][bit_i] = ones_l[lvl][bit_i] & ones_l[lvl][bit_i-DIST];
      end else begin : g_pass
        assign ones_l[lvl+1][bit_i] = ones_l[lvl][bit_i];
      end
    end
  end

  // Flip every bit up to and including the lowest zero of sum_i.
  assign res_o = sum_i ^ ({WIDTH{inc_i}} & ones_l[LEVELS]);

  always_comb begin
    AST_INC_ADDS_ONE: assert (!inc_i || (res_o == sum_i + WIDTH'(1)));  // R3
    AST_PASS_THROUGH: assert (inc_i || (res_o == sum_i));               // R4
  end
endmodule

// File: rtl/modm1_prefix_adder.sv
module modm1_prefix_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] plain_sum;
  logic             grp_gen;
  logic             grp_prop;
  logic             inc_sel;

  modm1_prefix_net #(.WIDTH(WIDTH)) u_net (
    .a_i         (a_i),
    .b_i         (b_i),
    .plain_sum_o (plain_sum),
    .grp_gen_o   (grp_gen),
    .grp_prop_o  (grp_prop)
  );

  // The carry out folds back in; an all-ones sum wraps to the single zero.
  assign inc_sel = grp_gen | grp_prop;

  modm1_excess_one #(.WIDTH(WIDTH)) u_inc (
    .sum_i (plain_sum),
    .inc_i (inc_sel),
    .res_o (sum_o)
  );

  always_comb begin
    if (a_i != ALL_ONES && b_i != ALL_ONES) begin
      AST_NO_ALL_ONES: assert (sum_o != ALL_ONES);                                      // R2
      AST_WRAP_ZERO:   assert (({1'b0, a_i} + {1'b0, b_i}) != {1'b0, ALL_ONES} || sum_o == '0); // R2
      AST_ZERO_ID:     assert (b_i != '0 || sum_o == a_i);                               // R5
    end
  end
endmodule

// File: tb/modm1_prefix_adder_tb.sv
module modm1_prefix_adder_tb_top;
  logic clk;
  logic rst_n;
  logic [7:0] a8, b8;
  logic [7:0] s8;
  logic [2:0] a3, b3;
  logic [2:0] s3;

  typedef struct {
    bit narrow;
    int a;
    int b;
    int exp;
    string req;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  modm1_prefix_adder #(.WIDTH(8)) dut_i (.a_i(a8), .b_i(b8), .sum_o(s8));
  modm1_prefix_adder #(.WIDTH(3)) dut_n (.a_i(a3), .b_i(b3), .sum_o(s3));

  // Names the requirement that a given operand pair exercises.
  function automatic string classify(int a, int b, int m);
    if (a == 0 || b == 0) return "R5";
    if (a + b == m)       return "R2";
    if (a + b > m)        return "R3";
    return "R4";
  endfunction

  task automatic drive(bit narrow, int a, int b);
    item_t it;
    int m;
    m = narrow ? 7 : 255;
    @(posedge clk);
    if (narrow) begin
      a3 = 3'(a);
      b3 = 3'(b);
    end else begin
      a8 = 8'(a);
      b8 = 8'(b);
    end
    it.narrow = narrow;
    it.a      = a;
    it.b      = b;
    it.exp    = (a + b) % m;   // R1
    it.req    = narrow ? "R6" : classify(a, b, m);
    sb_q.push_back(it);
  endtask

  // Monitor: compare half a period after each drive.
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      int act;
      it  = sb_q.pop_front();
      act = it.narrow ? int'(s3) : int'(s8);
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s/R1: a=%0d b=%0d actual=%0d expected=%0d",
                 it.req, it.a, it.b, act, it.exp);
      end
    end
  end

  initial begin
    a8 = '0; b8 = '0; a3 = '0; b3 = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-like idle: zero plus zero gives zero (R5)
    drive(1'b0, 0, 0);
    // Boundary cases first: wrap to zero R2, maximal carry fold R3
    drive(1'b0, 254, 1);
    drive(1'b0, 170, 85);
    drive(1'b0, 254, 254);
    drive(1'b0, 128, 128);
    drive(1'b0, 100, 27);
    // Narrow width exhaustive (R6)
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        drive(1'b1, a, b);
    // Default width exhaustive (R1..R5)
    for (int a = 0; a < 255; a++)
      for (int b = 0; b < 255; b++)
        drive(1'b0, a, b);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule